// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt lines, grouped in banks of eight, and turns their activity into one interrupt request. Each line carries its own 3-bit trigger code that selects level sensing (active low or active high) or edge sensing (falling, rising or both). Every line is first resynchronised to the block clock. The sensed result lands in a pending register. The pending bits that are not masked are ORed into the request output.

Software uses a small word-wide register port. A write port takes an enable, an address and data, and a separate read address returns a register combinationally. Each bank of eight lines has its own mode word. One word holds the per-line mask. A pending word reads the latched status, and writing ones to it clears edge-triggered bits. Level-triggered lines cannot be cleared by software. Their pending bit tracks the input, so the source must remove the level to drop the request.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, `irq_o` is 0, and every mode field holds code 100 (rising edge), so each mode word reads 24'h924924.
- R2: Register map with default parameters: address g (0..2) is the mode word for lines 8g..8g+7, where line 8g+k uses bits [3k+2:3k]. Address 3 is the mask word, address 4 is the pending word, and other addresses read 0. Bit n of the mask and pending words belongs to line n.
- R3: In a mode field, the two upper bits select the sensing: 00 is level, 01 is falling edge, 10 is rising edge and 11 is both edges. The lowest bit picks the active level for level sensing (0 low, 1 high) and has no effect on the edge codes, so 010 and 011 both sense falling edges.
- R4: An edge-sensed line's pending bit, once set, stays set after the input returns to idle, until software clears it.
- R5: Writing 1 to bit n of the pending word clears an edge-sensed pending bit n. Writing 0 leaves it unchanged.
- R6: A level-sensed line's pending bit equals its synchronised active condition. A clearing write while the level is still active leaves it at 1, and it falls to 0 by itself once the level goes away.
- R7: `irq_o` is 1 exactly when some pending bit has its mask bit at 0. A masked line's pending bit still reads back.
- R8: If an edge and a clearing write for the same line land in the same cycle, the bit ends up set.
- R9: An input change driven between clock edges shows in the pending word, and so in `irq_o`, after the third following rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 24 | External interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 24 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 24 | Read data for rd_addr_i, combinational |
| irq_o | output | 1 | Request: OR of the unmasked pending bits |

## Verification
The bench drives line changes and register writes on the falling clock edge. Results are sampled on a later falling edge, away from the active edge. A line change counts three rising edges to pending: two synchroniser flops, then the pending register. The bench checks that the pending bit is still 0 after two edges and is 1 after the third. A register write takes effect at the next rising edge. A read is combinational, so the bench checks it on the falling edge that follows. For the set-over-clear case, the clearing write is placed so that it is sampled on the same rising edge that latches the edge.

// File: rtl/eis_pkg.sv
package eis_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_FALL  = 2'b01,
        SENSE_RISE  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_kind_e;

    localparam logic [MODE_W-1:0] MODE_RESET = 3'b100;

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eis_detect.sv
module eis_detect
    import eis_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              now_i,
    input  logic              prev_i,
    output logic              level_o,
    output logic              active_o,
    output logic              hit_o
);

    sense_kind_e kind;
    logic        rise;
    logic        fall;

    always_comb begin
        kind     = sense_kind_e'(mode_i[MODE_W-1:1]);
        rise     = now_i & ~prev_i;
        fall     = ~now_i & prev_i;
        level_o  = (kind == SENSE_LEVEL);
        active_o = level_o & (now_i == mode_i[0]);
        unique case (kind)
            SENSE_FALL: hit_o = fall;
            SENSE_RISE: hit_o = rise;
            SENSE_BOTH: hit_o = rise | fall;
            default:    hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int NUM_GROUPS      = 3,
    parameter int LINES_PER_GROUP = 8,
    parameter int SYNC_STAGES     = 2,
    localparam int NUM_LINES = NUM_GROUPS * LINES_PER_GROUP,
    localparam int MODE_BITS = LINES_PER_GROUP * MODE_W,
    localparam int DATA_W    = (NUM_LINES > MODE_BITS) ? NUM_LINES : MODE_BITS,
    localparam int ADDR_W    = $clog2(NUM_GROUPS + 2)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 irq_o
);

    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_GROUPS);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_GROUPS + 1);

    typedef struct packed {
        logic [NUM_LINES-1:0][MODE_W-1:0] mode;
        logic [NUM_LINES-1:0]             mask;
        logic [NUM_LINES-1:0]             pend;
        logic [NUM_LINES-1:0]             prev;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] is_level;
    logic [NUM_LINES-1:0] level_act;
    logic [NUM_LINES-1:0] edge_hit;
    logic [NUM_LINES-1:0] clr_vec;

    eis_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (line_i),
        .q_o    (sync_lvl)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        eis_detect u_det (
            .mode_i   (st_q.mode[i]),
            .now_i    (sync_lvl[i]),
            .prev_i   (st_q.prev[i]),
            .level_o  (is_level[i]),
            .active_o (level_act[i]),
            .hit_o    (edge_hit[i])
        );
    end

    always_comb begin
        clr_vec = (wr_en_i && wr_addr_i == PEND_ADDR) ? wr_data_i[NUM_LINES-1:0] : '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_lvl;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (wr_en_i && wr_addr_i == ADDR_W'(g)) begin
                for (int k = 0; k < LINES_PER_GROUP; k++) begin
                    st_d.mode[g*LINES_PER_GROUP+k] = wr_data_i[k*MODE_W +: MODE_W];
                end
            end
        end
        if (wr_en_i && wr_addr_i == MASK_ADDR) begin
            st_d.mask = wr_data_i[NUM_LINES-1:0];
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (is_level[i]) begin
                st_d.pend[i] = level_act[i];
            end else begin
                st_d.pend[i] = (st_q.pend[i] & ~clr_vec[i]) | edge_hit[i];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode <= {NUM_LINES{MODE_RESET}};
            st_q.mask <= '1;
            st_q.pend <= '0;
            st_q.prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (rd_addr_i == ADDR_W'(g)) begin
                for (int k = 0; k < LINES_PER_GROUP; k++) begin
                    rd_data_o[k*MODE_W +: MODE_W] = st_q.mode[g*LINES_PER_GROUP+k];
                end
            end
        end
        if (rd_addr_i == MASK_ADDR) begin
            rd_data_o[NUM_LINES-1:0] = st_q.mask;
        end
        if (rd_addr_i == PEND_ADDR) begin
            rd_data_o[NUM_LINES-1:0] = st_q.pend;
        end
    end

    assign irq_o = |(st_q.pend & ~st_q.mask);

endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
    parameter int NL = 24
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          irq_i,
    input logic [NL-1:0] pend_i,
    input logic [NL-1:0] mask_i,
    input logic [NL-1:0] is_level_i,
    input logic [NL-1:0] level_act_i,
    input logic [NL-1:0] clr_i
);

    logic first_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        first_q |-> (mask_i == '1 && pend_i == '0 && !irq_i)); // R1

    AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(pend_i & ~is_level_i & ~clr_i) & ~pend_i) == '0)); // R4

    AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(level_act_i & is_level_i) & ~pend_i) == '0)); // R6

    AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (pend_i != '0)); // R7

endmodule

bind ext_irq_sense eis_checker #(.NL(NUM_LINES)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_o),
    .pend_i      (st_q.pend),
    .mask_i      (st_q.mask),
    .is_level_i  (is_level),
    .level_act_i (level_act),
    .clr_i       (clr_vec)
);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_PEND = 3'd4;
    localparam logic [23:0] ALL_RISE = 24'h924924;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] lines = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [23:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_sense u_ext_irq_sense (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .line_i    (lines),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    function automatic logic [23:0] put(input logic [23:0] w, input int k, input logic [2:0] c);
        logic [23:0] r;
        r = w;
        r[k*3 +: 3] = c;
        return r;
    endfunction

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pend_bit(input string req, input int n, input logic exp);
        logic [23:0] v;
        rd(A_PEND, v);
        check(req, {23'd0, v[n]}, {23'd0, exp});
    endtask

    task automatic t_reset();
        logic [23:0] v;
        for (int g = 0; g < 3; g++) begin
            rd(3'(g), v);
            check("R1 mode reset", v, ALL_RISE);
        end
        rd(A_MASK, v); check("R1 mask reset", v, 24'hFFFFFF);
        rd(A_PEND, v); check("R1 pend reset", v, 24'h0);
        check("R1 irq reset", {23'd0, irq}, 24'd0);
        rd(3'd5, v); check("R2 unmapped read", v, 24'h0);
    endtask

    task automatic t_rising();
        wr(A_MASK, ~(24'h1 << 3));
        @(negedge clk); lines[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        pend_bit("R9 not yet after two edges", 3, 1'b0);
        @(posedge clk); @(negedge clk);
        pend_bit("R9 pending after third edge", 3, 1'b1);
        check("R7 irq on unmasked pend", {23'd0, irq}, 24'd1);
        lines[3] = 1'b0;
        settle();
        pend_bit("R4 sticky after idle", 3, 1'b1);
        wr(A_PEND, 24'h0);
        pend_bit("R5 zero write keeps", 3, 1'b1);
        wr(A_PEND, 24'h1 << 3);
        pend_bit("R5 clear", 3, 1'b0);
        check("R7 irq drops", {23'd0, irq}, 24'd0);
    endtask

    task automatic t_falling();
        logic [23:0] w, v;
        w = put(put(ALL_RISE, 1, 3'b010), 2, 3'b011);
        wr(3'd1, w);
        rd(3'd1, v); check("R2 group1 readback", v, w);
        rd(3'd0, v); check("R2 group0 untouched", v, ALL_RISE);
        @(negedge clk); lines[9] = 1'b1; lines[10] = 1'b1;
        settle();
        pend_bit("R3 falling ignores rise", 9, 1'b0);
        pend_bit("R3 falling 011 ignores rise", 10, 1'b0);
        lines[9] = 1'b0; lines[10] = 1'b0;
        settle();
        pend_bit("R3 falling 010", 9, 1'b1);
        pend_bit("R3 falling 011", 10, 1'b1);
        wr(A_PEND, (24'h1 << 9) | (24'h1 << 10));
        pend_bit("R5 clear line9", 9, 1'b0);
    endtask

    task automatic t_both();
        wr(3'd2, put(ALL_RISE, 1, 3'b110));
        @(negedge clk); lines[17] = 1'b1;
        settle();
        pend_bit("R3 both on rise", 17, 1'b1);
        wr(A_PEND, 24'h1 << 17);
        pend_bit("R5 clear line17", 17, 1'b0);
        lines[17] = 1'b0;
        settle();
        pend_bit("R3 both on fall", 17, 1'b1);
        @(negedge clk); lines[17] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_PEND; wr_data = 24'h1 << 17;
        @(negedge clk);
        wr_en = 1'b0;
        pend_bit("R8 set wins over clear", 17, 1'b1);
        wr(A_PEND, 24'h1 << 17);
        pend_bit("R8 later clear works", 17, 1'b0);
    endtask

    task automatic t_level_high();
        wr(3'd2, put(put(ALL_RISE, 1, 3'b110), 4, 3'b001));
        @(negedge clk); lines[20] = 1'b1;
        settle();
        pend_bit("R6 high level pends", 20, 1'b1);
        wr(A_PEND, 24'h1 << 20);
        pend_bit("R6 clear refused while active", 20, 1'b1);
        lines[20] = 1'b0;
        settle();
        pend_bit("R6 drops with level", 20, 1'b0);
    endtask

    task automatic t_mask();
        wr(A_MASK, 24'hFFFFFF);
        @(negedge clk); lines[3] = 1'b1;
        settle();
        pend_bit("R7 masked still pending", 3, 1'b1);
        check("R7 masked no irq", {23'd0, irq}, 24'd0);
        wr(A_MASK, ~(24'h1 << 3));
        check("R7 unmask raises irq", {23'd0, irq}, 24'd1);
        wr(A_PEND, 24'h1 << 3);
        check("R7 irq after clear", {23'd0, irq}, 24'd0);
        lines[3] = 1'b0;
        settle();
    endtask

    task automatic t_level_low();
        wr(3'd0, put(ALL_RISE, 5, 3'b000));
        settle();
        pend_bit("R6 low level pends", 5, 1'b1);
        @(negedge clk); lines[5] = 1'b1;
        settle();
        pend_bit("R6 low level released", 5, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_level_high();
        t_mask();
        t_level_low();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule